// File: doc/BRIEF.md
# Phase-Accumulator Clock Generator Bank

This block makes several programmable-frequency square clocks from a single system clock. Each generator owns a 32-bit increment value N and a 32-bit phase accumulator. On every system clock the accumulator advances by N, wrapping modulo 2^32. The generator's output is the accumulator's top bit, so the output frequency is the system frequency times N divided by 2^32. A pin controller outside this block picks which generator drives which pin.

Software programs N for each generator through a write-only register port. The registers sit at an 8-byte stride: generator g is at byte address 8*g. An N of zero stops a generator and parks its output low. Writes of N at or above 2^31 are clipped to 2^31 - 1, which keeps every output at or below half the system clock. The write port uses a valid/ready handshake. Ready is held high at all times, so a write is taken in any cycle where valid is high and the port never applies back-pressure.

Top module: `phase_clkgen_bank`

## Requirements
- R1: While reset is asserted and after reset is released, every increment value and every accumulator is zero, so all generator outputs are low.
- R2: While a generator's increment N is nonzero, its accumulator adds N modulo 2^32 on every clock and its output is the accumulator's bit 31. With N = 2^28 the output has exactly 16 rising edges in any 256 consecutive clocks. With N = 2^30 it has exactly 64.
- R3: While a generator's increment is zero, its accumulator is cleared on the next clock and its output stays low.
- R4: A write whose data has bit 31 set stores 2^31 - 1 as the increment instead of the written value.
- R5: A write to one generator leaves the increment, accumulator and output of every other generator unaffected.
- R6: A write reaches generator g only when wr_addr equals 8*g. A write whose address bits [2:0] are not zero changes no generator.
- R7: wr_ready is always high. When wr_valid is high at a clock edge, the increment takes the new value at that edge. The accumulator keeps its phase and starts adding the new increment on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted. Always high |
| wr_addr | input | 5 | Byte address of the target increment register (8-byte stride) |
| wr_data | input | 32 | New increment value N |
| gen_clk | output | 4 | Generator outputs, one bit per generator |

## Verification
The assertions assume that wr_valid, wr_addr and wr_data hold known values at every clock edge once reset has been released. They also assume that wr_data is meaningful only in cycles where wr_valid is high. The stimulus changes inputs only on the falling clock edge. It raises wr_valid for exactly one cycle per write, and it drops wr_valid to zero between writes, so no two writes fall in the same cycle. Reset is held for several cycles before the first write, so no property looks back across reset.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  // Increment registers sit at an 8-byte stride.
  localparam int unsigned STRIDE_LSB = 3;

  typedef enum logic {
    ACC_PARK = 1'b0,
    ACC_STEP = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/clkgen_wr_decode.sv
module clkgen_wr_decode
  import clkgen_pkg::*;
#(
  parameter int unsigned NUM_GEN = 4,
  parameter int unsigned ADDR_W  = 5
) (
  input  logic               wr_fire,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic [NUM_GEN-1:0] sel
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LSB;

  logic aligned;
  assign aligned = (wr_addr[STRIDE_LSB-1:0] == '0);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_sel
    assign sel[g] = wr_fire && aligned &&
                    (wr_addr[ADDR_W-1:STRIDE_LSB] == IDX_W'(g));
  end
endmodule

// File: rtl/clkgen_incr_reg.sv
module clkgen_incr_reg #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] wdata,
  output logic [ACC_W-1:0] incr
);
  localparam logic [ACC_W-1:0] INCR_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic [ACC_W-1:0] clipped;
  assign clipped = wdata[ACC_W-1] ? INCR_MAX : wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    incr <= '0;
    else if (load) incr <= clipped;
  end

  // R4
  sat_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && wdata[ACC_W-1]) |=> (incr == INCR_MAX));

  // R5
  hold_unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(incr));
endmodule

// File: rtl/clkgen_phase_acc.sv
module clkgen_phase_acc
  import clkgen_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] incr,
  output logic             clk_o
);
  acc_mode_e        mode;
  logic [ACC_W-1:0] acc_q;

  assign mode = (incr == '0) ? ACC_PARK : ACC_STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else begin
      case (mode)
        ACC_STEP: acc_q <= acc_q + incr;
        default:  acc_q <= '0;
      endcase
    end
  end

  assign clk_o = acc_q[ACC_W-1];

  // R2
  rise_needs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> ($past(incr) != '0));

  // R3
  park_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incr == '0) |=> !clk_o);
endmodule

// File: rtl/phase_clkgen_bank.sv
module phase_clkgen_bank
  import clkgen_pkg::*;
#(
  parameter int unsigned NUM_GEN = 4,
  parameter int unsigned ACC_W   = 32,
  parameter int unsigned ADDR_W  = $clog2(NUM_GEN) + STRIDE_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ACC_W-1:0]   wr_data,
  output logic [NUM_GEN-1:0] gen_clk
);
  logic               wr_fire;
  logic [NUM_GEN-1:0] sel;
  logic [ACC_W-1:0]   incr [NUM_GEN];

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  clkgen_wr_decode #(.NUM_GEN(NUM_GEN), .ADDR_W(ADDR_W)) u_dec (
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .sel     (sel)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    clkgen_incr_reg #(.ACC_W(ACC_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sel[g]),
      .wdata (wr_data),
      .incr  (incr[g])
    );

    clkgen_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .incr  (incr[g]),
      .clk_o (gen_clk[g])
    );

    // R3
    zero_write_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == ADDR_W'(g << STRIDE_LSB) && wr_data == '0)
        |=> ##1 !gen_clk[g]);

    // R6
    misaligned_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr[STRIDE_LSB-1:0] != '0) |=> $stable(incr[g]));
  end
endmodule

// File: tb/test_phase_clkgen_bank.sv
module test_phase_clkgen_bank;
  localparam int NG = 4;
  localparam int AW = 5;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NG-1:0] gen_clk;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_tag = "R1";

  logic [NG-1:0] exp_q [$];
  string         tag_q [$];

  logic [DW-1:0] m_incr [NG];
  logic [DW-1:0] m_acc  [NG];

  always #4 clk = ~clk;

  phase_clkgen_bank i_phase_clkgen_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .gen_clk  (gen_clk)
  );

  // Expected-output producer: follows the requirements edge by edge.
  always @(posedge clk) begin
    logic [NG-1:0] e;
    for (int g = 0; g < NG; g++) begin
      if (!rst_n) begin
        m_acc[g]  = '0;
        m_incr[g] = '0;
      end else begin
        m_acc[g] = (m_incr[g] == 0) ? '0 : m_acc[g] + m_incr[g];
        if (wr_valid && wr_addr == AW'(g * 8))
          m_incr[g] = wr_data[31] ? 32'h7FFF_FFFF : wr_data;
      end
      e[g] = m_acc[g][31];
    end
    exp_q.push_back(e);
    tag_q.push_back(cur_tag);
  end

  // Monitor: compares design outputs against the queue away from the edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [NG-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if (gen_clk !== e) begin
        n_bad++;
        $display("FAIL %s: gen_clk actual=%b expected=%b", t, gen_clk, e);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    n_vec++;
    // R7: port never applies back-pressure
    if (wr_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R7: wr_ready actual=%b expected=1", wr_ready);
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
  endtask

  task automatic count_edges(input int g, input int win, input int want,
                             input string t);
    int   cnt = 0;
    logic prev;
    @(negedge clk);
    prev = gen_clk[g];
    for (int k = 0; k < win; k++) begin
      @(negedge clk);
      if (gen_clk[g] && !prev) cnt++;
      prev = gen_clk[g];
    end
    n_vec++;
    if (cnt != want) begin
      n_bad++;
      $display("FAIL %s: rising edges on gen %0d actual=%0d expected=%0d",
               t, g, cnt, want);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    cur_tag = "R1";
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2: frequency N = 2^28 on generator 0
    cur_tag = "R2";
    do_write(5'd0, 32'h1000_0000);
    repeat (20) @(negedge clk);
    count_edges(0, 256, 16, "R2");

    // R5: generator 1 programmed while generator 0 keeps running
    cur_tag = "R5";
    do_write(5'd8, 32'h4000_0000);
    repeat (10) @(negedge clk);
    count_edges(1, 256, 64, "R2");
    count_edges(0, 256, 16, "R5");

    // R4: out-of-range write is clipped
    cur_tag = "R4";
    do_write(5'd16, 32'hFFFF_FFFF);
    repeat (40) @(negedge clk);
    do_write(5'd16, 32'h8000_0001);
    repeat (40) @(negedge clk);

    // R6: misaligned address changes nothing; generator 3 stays low
    cur_tag = "R6";
    do_write(5'd28, 32'h1000_0000);
    repeat (50) @(negedge clk);
    do_write(5'd25, 32'h0000_0000);
    repeat (30) @(negedge clk);

    // R7: retune without phase reset
    cur_tag = "R7";
    do_write(5'd0, 32'h0800_0000);
    repeat (60) @(negedge clk);
    count_edges(0, 256, 8, "R7");

    // R3: zero increment parks output low
    cur_tag = "R3";
    do_write(5'd0, 32'h0);
    do_write(5'd8, 32'h0);
    repeat (30) @(negedge clk);
    n_vec++;
    if (gen_clk[1:0] !== 2'b00) begin
      n_bad++;
      $display("FAIL R3: gen_clk[1:0] actual=%b expected=00", gen_clk[1:0]);
    end

    // R1: reset mid-run clears everything
    cur_tag = "R1";
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    n_vec++;
    if (gen_clk !== '0) begin
      n_bad++;
      $display("FAIL R1: gen_clk actual=%b expected=0000", gen_clk);
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    finish_run();
  end
endmodule